// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two identical down-counting timers behind one word-addressed register port. Each timer counts on a shared timing strobe (`tick`). The count advances only when a shared, free-running prescale counter reaches a multiple of the divide chosen for that timer. Each timer can count 16 or 32 bits wide. When it reaches zero it either holds (one-shot), wraps through all ones (free-running), or reloads from its load register (periodic). It raises a sticky interrupt flag on every transition from nonzero to zero.

Software writes a start value through one of two paths. The direct path schedules a reload that is applied on the next tick. The background path only changes the value used by later periodic reloads. The single `irq` output is the OR of both timers' masked interrupt status.

Each timer runs a three-state machine:
- `ST_OFF`: the timer is disabled.
- `ST_RUN`: the timer is counting.
- `ST_HELD`: a one-shot timer is parked at zero.

Transitions:
- A control write with the enable bit set moves any state to `ST_RUN`.
- A control write with the enable bit clear moves any state to `ST_OFF`.
- A qualified step of a one-shot timer whose counted value is already zero moves `ST_RUN` to `ST_HELD`.
- A tick that applies a pending direct reload moves `ST_HELD` to `ST_RUN`.

Top module: `dt_dual_timer`

## Requirements
- R1: After reset, each timer reads value 0xFFFFFFFF, control 0x20, raw and masked status 0 and load 0, and `irq` is 0.
- R2: Control bits are: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit width (0 means 16-bit), bit 0 one-shot. The control value written reads back unchanged. While bit 7 is 0, ticks never change the value.
- R3: A write to the load register (word 0 of a timer) stores the value and arms a reload. The first tick seen while the timer is enabled copies load into the value instead of counting. While the timer is disabled, the reload stays armed.
- R4: A write to the background-load register (word 6) stores into load without arming a reload, so counting carries on from the current value. Reads of word 0 and of word 6 both return load.
- R5: On a qualified step, a nonzero count decrements by one. A zero count in free-running mode (bits 6 and 0 clear) wraps to all ones.
- R6: In one-shot mode (bit 0 set), a count of zero holds at zero on later steps.
- R7: In periodic mode (bit 6 set, bit 0 clear), a zero count reloads from load on the next qualified step.
- R8: A shared prescale counter advances on every tick from reset, whether or not a timer is enabled. Prescale codes 0, 1, 2 and 3 divide by 1, 16, 256 and 4096. A timer steps on a tick only when the counter value after that tick has its low 0, 4, 8 or 12 bits all zero.
- R9: With bit 1 clear, only bits 15:0 count. Steps and reloads write only the low half, and bits 31:16 keep their value.
- R10: The raw flag (word 4, bit 0) sets when the counted value goes from nonzero to zero. Any write to word 3 clears it. When a clear and a new zero crossing fall in the same cycle, the flag stays set.
- R11: Masked status (word 5, bit 0) is the raw flag ANDed with control bit 5. `irq` is the OR of both timers' masked status.
- R12: Word 1 returns the current value. Writes to word 1 are ignored.
- R13: Address bit 3 selects the timer (0 is the first, 1 is the second). Bits 2:0 select the word. Word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing strobe; one count opportunity per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address: timer select and word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | OR of both timers' masked interrupt status |

## Verification
Two functions can land in the same cycle: the interrupt clear written by software, and the zero crossing produced by a tick. The bench arms a timer at a count of one. It then raises `tick` and writes the clear register on the very same clock edge. The flag must read back as set, because the new crossing must not be lost. A separate clear-only write must then bring it to zero. Load writes that arrive with no tick, and control changes made while a reload is pending, are checked the same way: by reading the value at the first and second tick after the write.

// File: rtl/dt_pkg.sv
package dt_pkg;
    localparam int CTRL_W    = 8;
    localparam int CB_EN     = 7;
    localparam int CB_PER    = 6;
    localparam int CB_IE     = 5;
    localparam int CB_PS_HI  = 3;
    localparam int CB_PS_LO  = 2;
    localparam int CB_WIDE   = 1;
    localparam int CB_ONE    = 0;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

    typedef enum logic [2:0] {
        RG_LOAD   = 3'd0,
        RG_VALUE  = 3'd1,
        RG_CTRL   = 3'd2,
        RG_ICLR   = 3'd3,
        RG_RAW    = 3'd4,
        RG_MSK    = 3'd5,
        RG_BGLOAD = 3'd6,
        RG_PAD    = 3'd7
    } dt_reg_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } dt_state_e;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [PRE_W-1:0] cnt_adv
);
    logic [PRE_W-1:0] cnt_q;

    assign cnt_adv = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_adv;
    end

    AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int PRE_W    = 12,
    parameter int PRE_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PRE_W-1:0]  cnt_adv,
    input  logic              wr_load,
    input  logic              wr_bg,
    input  logic              wr_ctrl,
    input  logic              wr_iclr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] value_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              raw_o,
    output logic              msk_o
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    dt_state_e         st_q, st_d;
    logic [DATA_W-1:0] load_q, value_q, value_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic              pend_q, pend_d, flag_q;
    logic [PRE_W-1:0]  mask;
    logic              due, wide, hit;
    logic [DATA_W-1:0] cur, nxt, newcnt;

    // prescale qualification
    always_comb begin
        for (int b = 0; b < PRE_W; b++)
            mask[b] = (b < int'(ctrl_q[CB_PS_HI:CB_PS_LO]) * PRE_STEP);
    end
    assign due  = tick && ((cnt_adv & mask) == '0);
    assign wide = ctrl_q[CB_WIDE];
    assign cur  = wide ? value_q : {{UPPER_W{1'b0}}, value_q[NARROW_W-1:0]};

    // next state and counting action
    always_comb begin
        st_d   = st_q;
        nxt    = cur;
        pend_d = pend_q;
        unique case (st_q)
            ST_OFF: ;
            ST_RUN, ST_HELD: begin
                if (tick && pend_q) begin
                    nxt    = load_q;
                    pend_d = 1'b0;
                    st_d   = ST_RUN;
                end else if (due && st_q == ST_RUN) begin
                    if (cur == '0) begin
                        if (ctrl_q[CB_ONE])      st_d = ST_HELD;
                        else if (ctrl_q[CB_PER]) nxt  = load_q;
                        else                     nxt  = cur - 1'b1;
                    end else begin
                        nxt = cur - 1'b1;
                    end
                end
            end
            default: st_d = ST_OFF;
        endcase
        if (wr_ctrl) st_d = wdata[CB_EN] ? ST_RUN : ST_OFF;
        if (wr_load) pend_d = 1'b1;
    end

    always_comb begin
        value_d = wide ? nxt : {value_q[DATA_W-1:NARROW_W], nxt[NARROW_W-1:0]};
        newcnt  = wide ? nxt : {{UPPER_W{1'b0}}, nxt[NARROW_W-1:0]};
        hit     = (cur != '0) && (newcnt == '0);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            value_q <= '1;
            ctrl_q  <= CTRL_RESET;
            pend_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            value_q <= value_d;
            pend_q  <= pend_d;
            if (wr_load || wr_bg) load_q <= wdata;
            if (wr_ctrl)          ctrl_q <= wdata[CTRL_W-1:0];
            if (hit)              flag_q <= 1'b1;
            else if (wr_iclr)     flag_q <= 1'b0;
        end
    end

    assign load_o  = load_q;
    assign value_o = value_q;
    assign ctrl_o  = ctrl_q;
    assign raw_o   = flag_q;
    assign msk_o   = flag_q & ctrl_q[CB_IE];

    AST_OFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |=> $stable(value_q)); // R2
    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD) |-> (wide ? (value_q == '0) : (value_q[NARROW_W-1:0] == '0))); // R6
    AST_RELOAD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF && pend_q && tick) |=> (value_q[NARROW_W-1:0] == $past(load_q[NARROW_W-1:0]))); // R3
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick)); // R10
endmodule

// File: rtl/dt_dual_timer.sv
module dt_dual_timer
    import dt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int PRE_W    = 12,
    parameter int PRE_STEP = 4,
    parameter int NUM_CH   = 2,
    localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = 3 + CH_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [PRE_W-1:0]  cnt_adv;
    logic [CH_BITS-1:0] ch_sel;
    dt_reg_e           rg;
    logic [DATA_W-1:0] load_v  [NUM_CH];
    logic [DATA_W-1:0] value_v [NUM_CH];
    logic [CTRL_W-1:0] ctrl_v  [NUM_CH];
    logic [NUM_CH-1:0] raw_v, msk_v;

    assign ch_sel = addr[ADDR_W-1:3];
    assign rg     = dt_reg_e'(addr[2:0]);

    dt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_adv(cnt_adv)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (ch_sel == CH_BITS'(c));
        dt_channel #(
            .DATA_W(DATA_W), .NARROW_W(NARROW_W),
            .PRE_W(PRE_W), .PRE_STEP(PRE_STEP)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_adv(cnt_adv),
            .wr_load(sel && rg == RG_LOAD),
            .wr_bg  (sel && rg == RG_BGLOAD),
            .wr_ctrl(sel && rg == RG_CTRL),
            .wr_iclr(sel && rg == RG_ICLR),
            .wdata(wdata),
            .load_o(load_v[c]), .value_o(value_v[c]), .ctrl_o(ctrl_v[c]),
            .raw_o(raw_v[c]), .msk_o(msk_v[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CH_BITS'(c)) begin
                unique case (rg)
                    RG_LOAD, RG_BGLOAD: rdata = load_v[c];
                    RG_VALUE:           rdata = value_v[c];
                    RG_CTRL:            rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_v[c]};
                    RG_RAW:             rdata = {{(DATA_W-1){1'b0}}, raw_v[c]};
                    RG_MSK:             rdata = {{(DATA_W-1){1'b0}}, msk_v[c]};
                    RG_ICLR, RG_PAD:    rdata = '0;
                    default:            rdata = '0;
                endcase
            end
        end
    end

    assign irq = |msk_v;

    AST_IRQ_FROM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|raw_v)); // R11
endmodule

// File: tb/test_dt_dual_timer.sv
`timescale 1ns/1ps
module test_dt_dual_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int tick_total = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    logic [31:0] act_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    dt_dual_timer i_dt_dual_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // driver tasks
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
        tick_total += n;
    endtask

    task automatic tick_and_clear(input logic [3:0] a);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = a; wdata = 32'h0;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        tick_total += 1;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); addr = a; #1;
        exp_q.push_back(e); act_q.push_back(rdata); tag_q.push_back(tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk); #1;
        exp_q.push_back({31'b0, e}); act_q.push_back({31'b0, irq}); tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        logic [31:0] a, e;
        string t;
        forever begin
            @(posedge clk);
            while (act_q.size() > 0) begin
                a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=%08h expected=%08h", t, a, e);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r, k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(4'd1, 32'hFFFF_FFFF, "R1 value");
        chk(4'd2, 32'h20, "R1 control");
        chk(4'd4, 32'h0, "R1 raw");
        chk(4'd0, 32'h0, "R1 load");
        chk(4'd9, 32'hFFFF_FFFF, "R1 value ch1");
        chk_irq(1'b0, "R1 irq");

        // R12 value register ignores writes
        wr(4'd1, 32'h1234);
        chk(4'd1, 32'hFFFF_FFFF, "R12 value write ignored");

        // R3/R5 direct load, free-running
        wr(4'd0, 32'd5);
        wr(4'd2, 32'hA2);
        chk(4'd1, 32'hFFFF_FFFF, "R3 load deferred");
        chk(4'd2, 32'hA2, "R2 control readback");
        ticks(1);
        chk(4'd1, 32'd5, "R3 load applied on tick");
        ticks(4);
        chk(4'd1, 32'd1, "R5 decrement");
        chk(4'd4, 32'h0, "R10 no flag before zero");
        ticks(1);
        chk(4'd1, 32'd0, "R5 reach zero");
        chk(4'd4, 32'h1, "R10 flag on zero");
        chk(4'd5, 32'h1, "R11 masked");
        chk_irq(1'b1, "R11 irq");
        ticks(1);
        chk(4'd1, 32'hFFFF_FFFF, "R5 wrap");
        wr(4'd3, 32'h0);
        chk(4'd4, 32'h0, "R10 cleared");
        chk_irq(1'b0, "R11 irq low");

        // R6 one-shot
        wr(4'd0, 32'd2);
        wr(4'd2, 32'hA3);
        ticks(1);
        chk(4'd1, 32'd2, "R6 loaded");
        ticks(2);
        chk(4'd1, 32'd0, "R6 zero");
        chk(4'd4, 32'h1, "R10 one-shot flag");
        ticks(3);
        chk(4'd1, 32'd0, "R6 hold");
        wr(4'd3, 32'h0);
        ticks(2);
        chk(4'd1, 32'd0, "R6 still hold");
        chk(4'd4, 32'h0, "R10 no reflag at hold");

        // R9 16-bit mode
        wr(4'd0, 32'h0005_0001);
        wr(4'd2, 32'hA2);
        ticks(1);
        chk(4'd1, 32'h0005_0001, "R3 32-bit reload");
        wr(4'd2, 32'hA0);
        ticks(1);
        chk(4'd1, 32'h0005_0000, "R9 low half zero");
        chk(4'd4, 32'h1, "R10 16-bit flag");
        ticks(1);
        chk(4'd1, 32'h0005_FFFF, "R9 upper preserved on wrap");
        wr(4'd3, 32'h0);
        wr(4'd0, 32'h1234_0007);
        ticks(1);
        chk(4'd1, 32'h0005_0007, "R9 reload low half only");

        // R10 clear and crossing in one cycle
        wr(4'd0, 32'd1);
        ticks(1);
        chk(4'd1, 32'h0005_0001, "R9 reload to one");
        tick_and_clear(4'd3);
        chk(4'd1, 32'h0005_0000, "R10 crossing value");
        chk(4'd4, 32'h1, "R10 set wins over clear");
        wr(4'd3, 32'h0);
        chk(4'd4, 32'h0, "R10 clear alone");
        wr(4'd2, 32'h00);

        // R7 periodic on timer 1
        wr(4'd8, 32'd3);
        wr(4'd10, 32'hE2);
        ticks(1);
        chk(4'd9, 32'd3, "R13 ch1 load");
        ticks(3);
        chk(4'd9, 32'd0, "R7 zero");
        chk(4'd12, 32'h1, "R10 ch1 flag");
        ticks(1);
        chk(4'd9, 32'd3, "R7 reload");
        wr(4'd11, 32'h0);

        // R4 background load
        wr(4'd14, 32'd10);
        chk(4'd8, 32'd10, "R4 load readback");
        chk(4'd14, 32'd10, "R4 bg readback");
        ticks(1);
        chk(4'd9, 32'd2, "R4 no immediate reload");
        ticks(2);
        chk(4'd9, 32'd0, "R7 zero again");
        ticks(1);
        chk(4'd9, 32'd10, "R4 periodic uses bg value");
        wr(4'd11, 32'h0);

        // R2/R3 disabled timer with pending load
        wr(4'd10, 32'h02);
        wr(4'd8, 32'd50);
        ticks(3);
        chk(4'd9, 32'd10, "R2 disabled no change");

        // R8 divide by 16
        wr(4'd10, 32'h86);
        ticks(1);
        chk(4'd9, 32'd50, "R3 pending applied after enable");
        r = tick_total % 16;
        k = (r == 0) ? 16 : 16 - r;
        if (k > 1) ticks(k - 1);
        chk(4'd9, 32'd50, "R8 no step before boundary");
        ticks(1);
        chk(4'd9, 32'd49, "R8 step at boundary");
        ticks(16);
        chk(4'd9, 32'd48, "R8 step after 16");

        // R11 masking
        wr(4'd10, 32'h82);
        wr(4'd8, 32'd1);
        ticks(2);
        chk(4'd9, 32'd0, "R11 ch1 zero");
        chk(4'd12, 32'h1, "R11 raw set");
        chk(4'd13, 32'h0, "R11 masked off");
        chk_irq(1'b0, "R11 irq masked");
        wr(4'd10, 32'hA2);
        chk(4'd13, 32'h1, "R11 masked on");
        chk_irq(1'b1, "R11 irq via ch1");
        chk(4'd15, 32'h0, "R13 pad word");
        chk(4'd4, 32'h0, "R13 ch0 flag untouched");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule